// File: doc/BRIEF.md
# Four-Channel Square Tone Generator

A sound block with four independent square-wave voices, set up by 16-bit writes on a small I/O port bus with a 4-bit address. Each voice has a 16-bit period register and a 16-bit down-counter. The counter advances only on cycles where the shared `tick_i` enable is high. When the counter reaches zero it reloads from the period register. The voice's polarity bit inverts each time the counter steps from one to zero, so a period value P gives a square wave whose half-period is P+1 ticks.

Two further ports each hold one 8-bit volume byte for each of two voices. The block drives the per-voice polarity bits and volume bytes to a downstream mixer, which is outside this block. A period value of zero silences the voice: its output stays at high polarity. Writing a new period leaves the running count alone, so the new pitch starts at the next reload.

Top module: `tone_gen4`

## Requirements
- R1: After reset all period registers, counters and volumes are 0, and every bit of `tone_o` is 1.
- R2: A write to port address 4, 5, 6 or 7 loads `wr_data_i` into the period register of voice 0, 1, 2 or 3 respectively, on the clock edge that samples `wr_en_i`.
- R3: On a clock edge with `tick_i` high, a non-zero counter decrements by one. With `tick_i` low, the counter holds its value.
- R4: On a clock edge with `tick_i` high, a counter at 0 loads the voice's current period value.
- R5: A voice's polarity bit inverts on the tick edge where its counter steps from 1 to 0. With `tick_i` high on every cycle and period P, the first inversion comes P+1 ticks after reset and each later half-period lasts P+1 ticks.
- R6: While a voice's period register is 0, its `tone_o` bit is 1 from the next clock edge on, and it does not toggle.
- R7: Writing a period register does not restart or change the running counter. The new value is first used at the next reload.
- R8: A write to address 8 puts `wr_data_i[15:8]` into voice 0's volume and `wr_data_i[7:0]` into voice 1's volume. Address 9 does the same for voices 2 and 3. Voice i's volume appears on `vol_o[8*i+7:8*i]` after the write edge.
- R9: Writes to addresses 0-3 and 10-15 change no period and no volume.
- R10: `tone_o` changes only on edges with `tick_i` high, except for the forced-high case of R6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | Counter advance enable |
| wr_en_i | input | 1 | Port write strobe |
| wr_addr_i | input | 4 | Port address |
| wr_data_i | input | 16 | Port write data |
| tone_o | output | 4 | Polarity bit per voice, bit i = voice i |
| vol_o | output | 32 | Volume byte per voice, voice i at [8*i+7:8*i] |

## Verification
Period and volume registers take their new value on the edge that samples the write strobe, so volumes appear on `vol_o` one edge after the write is presented. The polarity bit changes on the same tick edge on which the counter leaves 1. The bench drives every input just after a falling edge and reads the outputs at the next falling edge. Each read therefore reflects exactly one rising edge. Half-periods are counted in falling edges while `tick_i` is held high, which makes the count equal to the number of ticks. A reference model clocked on the same rising edge is compared at those falling edges during the random phase.

// File: rtl/tone_pkg.sv
package tone_pkg;
  localparam int unsigned PORT_W = 4;
  localparam int unsigned WORD_W = 16;

  typedef logic [PORT_W-1:0] port_t;
  typedef logic [WORD_W-1:0] word_t;

  typedef struct packed {
    logic  en;
    port_t addr;
    word_t data;
  } io_wr_t;
endpackage

// File: rtl/tone_port_decode.sv
module tone_port_decode
  import tone_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned PER_BASE = 4,
  parameter int unsigned VOL_BASE = 8
) (
  input  io_wr_t              wr_i,
  output logic [NUM_CH-1:0]   per_we_o,
  output logic [NUM_CH/2-1:0] vol_we_o
);
  localparam int unsigned NUM_PAIR = NUM_CH / 2;

  for (genvar i = 0; i < NUM_CH; i++) begin : g_per
    assign per_we_o[i] = wr_i.en && (wr_i.addr == port_t'(PER_BASE + i));
  end

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_vol
    assign vol_we_o[p] = wr_i.en && (wr_i.addr == port_t'(VOL_BASE + p));
  end
endmodule

// File: rtl/tone_channel.sv
module tone_channel #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             per_we_i,
  input  logic [CNT_W-1:0] per_d_i,
  output logic             tone_o,
  output logic [CNT_W-1:0] per_o,
  output logic [CNT_W-1:0] cnt_o
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] per_q, cnt_q;
  logic             pol_q;
  logic             cnt_zero, cnt_last;

  assign cnt_zero = (cnt_q == '0);
  assign cnt_last = (cnt_q == ONE);

  // period change does not touch the running count
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       per_q <= '0;
    else if (per_we_i) per_q <= per_d_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else if (tick_i) cnt_q <= cnt_zero ? per_q : cnt_q - ONE;
  end

  // zero period parks the output high
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  pol_q <= 1'b1;
    else if (per_q == '0)         pol_q <= 1'b1;
    else if (tick_i && cnt_last)  pol_q <= ~pol_q;
  end

  assign tone_o = pol_q;
  assign per_o  = per_q;
  assign cnt_o  = cnt_q;
endmodule

// File: rtl/tone_vol_bank.sv
module tone_vol_bank
  import tone_pkg::*;
#(
  parameter int unsigned NUM_CH = 4,
  parameter int unsigned VOL_W  = 8
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic [NUM_CH/2-1:0]       vol_we_i,
  input  word_t                     data_i,
  output logic [NUM_CH*VOL_W-1:0]   vol_o
);
  localparam int unsigned NUM_PAIR = NUM_CH / 2;

  logic [VOL_W-1:0] vol_q [NUM_CH];

  for (genvar p = 0; p < NUM_PAIR; p++) begin : g_pair
    // high byte to the even voice, low byte to the odd voice
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vol_q[2*p]   <= '0;
        vol_q[2*p+1] <= '0;
      end else if (vol_we_i[p]) begin
        vol_q[2*p]   <= data_i[2*VOL_W-1:VOL_W];
        vol_q[2*p+1] <= data_i[VOL_W-1:0];
      end
    end
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_out
    assign vol_o[i*VOL_W +: VOL_W] = vol_q[i];
  end
endmodule

// File: rtl/tone_gen4.sv
module tone_gen4
  import tone_pkg::*;
#(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned VOL_W    = 8,
  parameter int unsigned PER_BASE = 4,
  parameter int unsigned VOL_BASE = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    tick_i,
  input  logic                    wr_en_i,
  input  logic [3:0]              wr_addr_i,
  input  logic [15:0]             wr_data_i,
  output logic [NUM_CH-1:0]       tone_o,
  output logic [NUM_CH*VOL_W-1:0] vol_o
);
  localparam int unsigned CNT_W    = WORD_W;
  localparam int unsigned NUM_PAIR = NUM_CH / 2;

  io_wr_t              wr;
  logic [NUM_CH-1:0]   per_we;
  logic [NUM_PAIR-1:0] vol_we;
  logic [CNT_W-1:0]    per_q [NUM_CH];
  logic [CNT_W-1:0]    cnt_q [NUM_CH];

  assign wr.en   = wr_en_i;
  assign wr.addr = wr_addr_i;
  assign wr.data = wr_data_i;

  tone_port_decode #(
    .NUM_CH  (NUM_CH),
    .PER_BASE(PER_BASE),
    .VOL_BASE(VOL_BASE)
  ) u_dec (
    .wr_i    (wr),
    .per_we_o(per_we),
    .vol_we_o(vol_we)
  );

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    tone_channel #(.CNT_W(CNT_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .tick_i  (tick_i),
      .per_we_i(per_we[i]),
      .per_d_i (wr_data_i),
      .tone_o  (tone_o[i]),
      .per_o   (per_q[i]),
      .cnt_o   (cnt_q[i])
    );
  end

  tone_vol_bank #(
    .NUM_CH(NUM_CH),
    .VOL_W (VOL_W)
  ) u_vol (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .vol_we_i(vol_we),
    .data_i  (wr_data_i),
    .vol_o   (vol_o)
  );
endmodule

// File: rtl/tone_gen4_chk.sv
module tone_gen4_chk #(
  parameter int unsigned NUM_CH   = 4,
  parameter int unsigned VOL_W    = 8,
  parameter int unsigned PER_BASE = 4,
  parameter int unsigned VOL_BASE = 8
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic                    tick_i,
  input logic                    wr_en_i,
  input logic [3:0]              wr_addr_i,
  input logic [15:0]             wr_data_i,
  input logic [NUM_CH-1:0]       tone_o,
  input logic [NUM_CH*VOL_W-1:0] vol_o,
  input logic [15:0]             per_q [NUM_CH],
  input logic [15:0]             cnt_q [NUM_CH]
);
  logic addr_unused;
  assign addr_unused = !((wr_addr_i >= 4'(PER_BASE)) && (wr_addr_i < 4'(PER_BASE + NUM_CH)))
                    && !((wr_addr_i >= 4'(VOL_BASE)) && (wr_addr_i < 4'(VOL_BASE + NUM_CH/2)));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    a_r2_period_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == 4'(PER_BASE + i)) |=> per_q[i] == $past(wr_data_i));
    a_r3_decrement: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && cnt_q[i] != 16'd0) |=> cnt_q[i] == $past(cnt_q[i]) - 16'd1);
    a_r3_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !tick_i |=> $stable(cnt_q[i]));
    a_r4_reload: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && cnt_q[i] == 16'd0) |=> cnt_q[i] == $past(per_q[i]));
    a_r5_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i && cnt_q[i] == 16'd1 && per_q[i] != 16'd0) |=> tone_o[i] != $past(tone_o[i]));
    a_r6_park_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (per_q[i] == 16'd0) |=> tone_o[i]);
    a_r10_no_tick_stable: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!tick_i && per_q[i] != 16'd0) |=> $stable(tone_o[i]));
    a_r9_period_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && addr_unused) |=> $stable(per_q[i]));
  end

  for (genvar p = 0; p < NUM_CH/2; p++) begin : g_pair
    a_r8_volume_split: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && wr_addr_i == 4'(VOL_BASE + p)) |=>
        (vol_o[2*p*VOL_W +: VOL_W] == $past(wr_data_i[2*VOL_W-1:VOL_W])) &&
        (vol_o[(2*p+1)*VOL_W +: VOL_W] == $past(wr_data_i[VOL_W-1:0])));
  end

  a_r9_volume_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_unused) |=> $stable(vol_o));
endmodule

bind tone_gen4 tone_gen4_chk #(
  .NUM_CH  (NUM_CH),
  .VOL_W   (VOL_W),
  .PER_BASE(PER_BASE),
  .VOL_BASE(VOL_BASE)
) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .tick_i   (tick_i),
  .wr_en_i  (wr_en_i),
  .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i),
  .tone_o   (tone_o),
  .vol_o    (vol_o),
  .per_q    (per_q),
  .cnt_q    (cnt_q)
);

// File: tb/sim_tone_gen4.sv
module sim_tone_gen4;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  tone;
  logic [31:0] vol;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  always #4 clk = ~clk;

  tone_gen4 u0 (
    .clk_i    (clk),
    .rst_ni   (rst_n),
    .tick_i   (tick),
    .wr_en_i  (wr_en),
    .wr_addr_i(wr_addr),
    .wr_data_i(wr_data),
    .tone_o   (tone),
    .vol_o    (vol)
  );

  // reference model built from the requirements
  logic [15:0] m_per [4];
  logic [15:0] m_cnt [4];
  logic        m_pol [4];
  logic [7:0]  m_vol [4];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 4; i++) begin
        m_per[i] <= '0; m_cnt[i] <= '0; m_pol[i] <= 1'b1; m_vol[i] <= '0;
      end
    end else begin
      for (int i = 0; i < 4; i++) begin
        if (tick) begin
          if (m_cnt[i] == 0) m_cnt[i] <= m_per[i];
          else begin
            m_cnt[i] <= m_cnt[i] - 16'd1;
            if (m_cnt[i] == 1) m_pol[i] <= ~m_pol[i];
          end
        end
        if (m_per[i] == 0) m_pol[i] <= 1'b1;
      end
      if (wr_en) begin
        if (wr_addr >= 4 && wr_addr <= 7) m_per[wr_addr-4] <= wr_data;
        if (wr_addr == 8) begin m_vol[0] <= wr_data[15:8]; m_vol[1] <= wr_data[7:0]; end
        if (wr_addr == 9) begin m_vol[2] <= wr_data[15:8]; m_vol[3] <= wr_data[7:0]; end
      end
    end
  end

  function automatic logic [3:0] exp_tone();
    logic [3:0] t;
    for (int i = 0; i < 4; i++) t[i] = m_pol[i];
    return t;
  endfunction

  function automatic logic [31:0] exp_vol();
    return {m_vol[3], m_vol[2], m_vol[1], m_vol[0]};
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    tick = 0; wr_en = 0; rst_n = 0;
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic wr(input logic [3:0] a, input logic [15:0] d);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
  endtask

  // counts ticks (tick held high) until tone bit ch changes
  task automatic wait_toggle(input int ch, output int ticks);
    logic start;
    start = tone[ch];
    ticks = 0;
    do begin
      @(negedge clk);
      ticks++;
    end while (tone[ch] == start && ticks < 70000);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    int pv [4];
    int last [4];
    int ntog [4];
    int t;
    logic [3:0] prev;
    logic [3:0] a;

    // R1 reset state
    do_reset();
    check("R1 tone after reset", 32'(tone), 32'hF);
    check("R1 vol after reset", vol, 32'h0);

    // R2 R5 R6 half periods per voice
    pv = '{3, 1, 7, 0};
    wr(4'd4, 16'(pv[0])); wr(4'd5, 16'(pv[1]));
    wr(4'd6, 16'(pv[2])); wr(4'd7, 16'(pv[3]));
    for (int i = 0; i < 4; i++) begin last[i] = 0; ntog[i] = 0; end
    prev = tone;
    check("R6 zero period high", 32'(tone[3]), 32'h1);
    tick = 1;
    for (int n = 1; n <= 80; n++) begin
      @(negedge clk);
      for (int i = 0; i < 4; i++) begin
        if (tone[i] != prev[i]) begin
          check($sformatf("R2 R5 half period voice %0d", i), 32'(n - last[i]), 32'(pv[i] + 1));
          last[i] = n; ntog[i]++;
        end
      end
      prev = tone;
    end
    check("R5 voice0 toggle count", 32'(ntog[0]), 32'(80 / 4));
    check("R5 voice2 toggle count", 32'(ntog[2]), 32'(80 / 8));
    check("R6 zero period no toggles", 32'(ntog[3]), 32'h0);

    // R6 writing zero mid-run parks the voice high
    wr(4'd6, 16'd0);
    @(negedge clk);
    check("R6 parked after zero write", 32'(tone[2]), 32'h1);

    // R3 R10 gating
    tick = 0;
    prev = tone;
    for (int n = 0; n < 10; n++) @(negedge clk);
    check("R3 R10 no tick keeps tone", 32'(tone), 32'(prev));

    // R7 period change waits for reload
    do_reset();
    wr(4'd4, 16'd5);
    tick = 1;
    wait_toggle(0, t);
    check("R5 first half period", 32'(t), 32'd6);
    @(negedge clk); @(negedge clk);
    wr(4'd4, 16'd2);
    wait_toggle(0, t);
    check("R7 running count kept", 32'(t + 3), 32'd6);
    wait_toggle(0, t);
    check("R7 new period at reload", 32'(t), 32'd3);
    tick = 0;

    // R8 volume split
    do_reset();
    wr(4'd8, 16'hA1B2);
    check("R8 voice0 volume", 32'(vol[7:0]), 32'hA1);
    check("R8 voice1 volume", 32'(vol[15:8]), 32'hB2);
    wr(4'd9, 16'h3C4D);
    check("R8 voice2 volume", 32'(vol[23:16]), 32'h3C);
    check("R8 voice3 volume", 32'(vol[31:24]), 32'h4D);

    // R9 unused addresses
    do_reset();
    for (int k = 0; k < 16; k++) begin
      if (k < 4 || k > 9) wr(4'(k), 16'h0003);
    end
    check("R9 vol unchanged", vol, 32'h0);
    tick = 1;
    for (int n = 0; n < 20; n++) @(negedge clk);
    check("R9 periods unchanged", 32'(tone), 32'hF);
    tick = 0;

    // random phase against the model
    void'($urandom(32'd4242));
    do_reset();
    for (int n = 0; n < 4000; n++) begin
      tick  = ($urandom_range(0, 3) != 0);
      wr_en = ($urandom_range(0, 5) == 0);
      a = 4'($urandom_range(0, 15));
      wr_addr = a;
      wr_data = (a >= 4 && a <= 7) ? 16'($urandom_range(0, 12)) : 16'($urandom);
      @(negedge clk);
      check("R3 R4 R5 R7 R10 random tone", 32'(tone), 32'(exp_tone()));
      check("R8 R9 random vol", vol, exp_vol());
    end
    wr_en = 0; tick = 0;

    done = 1;
    summary();
    $finish;
  end
endmodule